// File: doc/BRIEF.md
# Asynchronous Static RAM Lane Sequencer

This block sits between a synchronous host and an asynchronous 16-bit static RAM that uses a 20-bit word address. The host offers one request at a time through a valid/ready handshake. Each request carries a direction flag, a word address, write data and a two-bit lane mask. The sequencer turns the request into the pin pattern the memory expects on its two chip selects (one active low, one active high), its output enable, its write enable and its two byte-lane strobes. It also drives or releases the data bus. The bus appears as a separate output vector, input vector and drive enable, and the pad ring combines them into one bidirectional bus. Read results come back on a data vector together with a single-cycle valid strobe.

Every pin timing is worked out at elaboration from the clock period in picoseconds. Each analog limit is rounded up to whole clock cycles. After reset the sequencer waits out the supply settling time and holds the host off during that wait. Output enable stays high for the whole of every write. After each read, output enable is held high for a release gap before the bus can be driven again. The bus drivers of the sequencer and the memory therefore never overlap.

States: `ST_PWRUP` (supply wait) goes to `ST_IDLE` when its count runs out. `ST_IDLE` goes to `ST_RD_ACC` on an accepted read, or to `ST_WR_SETUP` on an accepted write. `ST_RD_ACC` goes to `ST_RD_REL` when the access count runs out, and the read data is captured on that edge. `ST_RD_REL` goes to `ST_IDLE` when the release count runs out. `ST_WR_SETUP` always goes to `ST_WR_PULSE`. `ST_WR_PULSE` goes to `ST_WR_RECOV` when the pulse count runs out. `ST_WR_RECOV` always goes to `ST_IDLE`.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low and the memory stays deselected (`mem_ce_n`=1, `mem_ce`=0) for PWR_CYC = ceil(T_PWR_PS/CLK_PS) rising edges. `req_ready` first reads high after edge PWR_CYC. A request presented during the wait is not taken until then.
- R2: `req_ready` is high only when the sequencer is idle. A request is taken at a rising edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle that follows.
- R3: A read drives `mem_ce_n`=0, `mem_ce`=1, `mem_we_n`=1 and `mem_oe_n`=0 for exactly RD_CYC cycles, where RD_CYC is the largest of the rounded read-cycle, access and output-enable times. The request address is on `mem_addr` during those cycles. Mask bit 0 enables the lower lane (bits 7:0, `mem_lb_n` low) and mask bit 1 enables the upper lane (bits 15:8, `mem_ub_n` low).
- R4: `rsp_valid` is high for exactly one cycle, in the cycle after edge A+RD_CYC, where A is the accepting edge. `rsp_rdata` holds the bus value on the enabled lanes and zero on the disabled lanes.
- R5: A write takes one setup cycle (data driven, `mem_we_n`=1). It then holds `mem_we_n` low for exactly WE_CYC cycles and ends with one recovery cycle at `mem_we_n`=1. `mem_oe_n` is high throughout. WE_CYC is the largest of the rounded pulse width, the rounded data setup, and the rounded write-cycle time minus two, and it is at least 1.
- R6: Only the lanes enabled in the mask are strobed during the write pulse, so a byte on a disabled lane keeps its stored value.
- R7: `mem_dq_oe` is never high while `mem_oe_n` is low. After a read, `req_ready` returns at edge A+RD_CYC+TURN_CYC, which leaves at least TURN_CYC = ceil(T_HZOE_PS/CLK_PS) cycles at `mem_oe_n`=1 before the bus is driven.
- R8: Whenever no access is under way (in reset, during the supply wait, during the release gap and while idle), the memory is deselected, every strobe is high and the bus is not driven.
- R9: `mem_addr` and `mem_dq_o` hold steady from the setup cycle through the recovery cycle of a write, so both are stable across the edge that ends the write.
- R10: A request with a zero mask runs the full sequence with both lane strobes high. A zero-mask write leaves memory unchanged and a zero-mask read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock whose period is CLK_PS |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 16 | Write data |
| req_lane_en | input | 2 | Lane mask: bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle read result strobe |
| rsp_rdata | output | 16 | Read result, disabled lanes zero |
| mem_addr | output | 20 | Memory address pins |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_ce | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 16 | Data returned by the memory |

## Verification
The response to a read is due in the cycle after edge A+RD_CYC. Ready comes back after edge A+RD_CYC+TURN_CYC for a read and after edge A+WE_CYC+2 for a write. The supply wait ends after edge PWR_CYC. The bench works out these cycle counts from the same picosecond values given to the design. It numbers the rising edges since reset, records the accepting edge of every request, and compares each result against that due edge. All sampling happens on the falling edge, halfway between the edge that produces a value and the edge that consumes it. A pin monitor measures each output-enable and write-enable window in whole cycles and compares its length and its address, data and lane pins with the request that opened it.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP    = 3'd0,
        ST_IDLE     = 3'd1,
        ST_RD_ACC   = 3'd2,
        ST_RD_REL   = 3'd3,
        ST_WR_SETUP = 3'd4,
        ST_WR_PULSE = 3'd5,
        ST_WR_RECOV = 3'd6
    } lane_state_t;

    // Round a picosecond figure up to whole clock cycles.
    function automatic int unsigned ps_to_cyc(input int unsigned ps, input int unsigned clk_ps);
        return (ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_timer.sv
`timescale 1ns/1ps
module sram_lane_timer #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= W'(RST_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sram_lane_fsm.sv
`timescale 1ns/1ps
module sram_lane_fsm
    import sram_lane_pkg::*;
#(
    parameter int unsigned LANES    = 2,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned RD_CYC   = 2,
    parameter int unsigned WE_CYC   = 1,
    parameter int unsigned TURN_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LANES-1:0] lane_mask,
    input  logic             tmr_zero,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             ce_n,
    output logic             ce,
    output logic             oe_n,
    output logic             we_n,
    output logic [LANES-1:0] lane_n,
    output logic             dq_oe
);
    localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_WE   = CNT_W'(WE_CYC - 1);
    localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);

    lane_state_t state, nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PWRUP;
        end else begin
            state <= nxt;
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign capture   = (state == ST_RD_ACC) && tmr_zero;

    // Transitions and timer loads
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_PWRUP: begin
                if (tmr_zero) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    if (req_write) begin
                        nxt = ST_WR_SETUP;
                    end else begin
                        nxt      = ST_RD_ACC;
                        tmr_load = 1'b1;
                        tmr_val  = LD_RD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (tmr_zero) begin
                    nxt      = ST_RD_REL;
                    tmr_load = 1'b1;
                    tmr_val  = LD_TURN;
                end
            end
            ST_RD_REL: begin
                if (tmr_zero) nxt = ST_IDLE;
            end
            ST_WR_SETUP: begin
                nxt      = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = LD_WE;
            end
            ST_WR_PULSE: begin
                if (tmr_zero) nxt = ST_WR_RECOV;
            end
            ST_WR_RECOV: begin
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Pin decode
    always_comb begin
        ce_n   = 1'b1;
        ce     = 1'b0;
        oe_n   = 1'b1;
        we_n   = 1'b1;
        lane_n = '1;
        dq_oe  = 1'b0;
        unique case (state)
            ST_RD_ACC: begin
                ce_n   = 1'b0;
                ce     = 1'b1;
                oe_n   = 1'b0;
                lane_n = ~lane_mask;
            end
            ST_WR_SETUP, ST_WR_RECOV: begin
                ce_n  = 1'b0;
                ce    = 1'b1;
                dq_oe = 1'b1;
            end
            ST_WR_PULSE: begin
                ce_n   = 1'b0;
                ce     = 1'b1;
                we_n   = 1'b0;
                lane_n = ~lane_mask;
                dq_oe  = 1'b1;
            end
            ST_PWRUP, ST_IDLE, ST_RD_REL: begin
                ce_n = 1'b1;
            end
            default: ce_n = 1'b1;
        endcase
    end
endmodule

// File: rtl/sram_lane_dpath.sv
`timescale 1ns/1ps
module sram_lane_dpath #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned LANE_W = 8,
    parameter int unsigned LANES  = 2,
    localparam int unsigned DATA_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_mask,
    input  logic [DATA_W-1:0] mem_dq_i,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_o,
    output logic [LANES-1:0]  lane_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    // Request latch: address, data and mask stay fixed for the whole access.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_dq_o  <= '0;
            lane_mask <= '0;
        end else if (accept) begin
            mem_addr  <= req_addr;
            mem_dq_o  <= req_wdata;
            lane_mask <= req_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= capture;
        end
    end

    // Per-lane capture: a disabled lane returns zero.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rsp_rdata[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rsp_rdata[g*LANE_W +: LANE_W] <= lane_mask[g] ? mem_dq_i[g*LANE_W +: LANE_W]
                                                              : '0;
            end
        end
    end
endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int unsigned CLK_PS    = 8000,
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned LANE_W    = 8,
    parameter int unsigned T_RC_PS   = 10000,
    parameter int unsigned T_AA_PS   = 10000,
    parameter int unsigned T_DOE_PS  = 5000,
    parameter int unsigned T_PWE_PS  = 7000,
    parameter int unsigned T_SD_PS   = 5500,
    parameter int unsigned T_WC_PS   = 10000,
    parameter int unsigned T_HZOE_PS = 5000,
    parameter int unsigned T_PWR_PS  = 100000000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [2*LANE_W-1:0]   req_wdata,
    input  logic [1:0]            req_lane_en,
    output logic                  rsp_valid,
    output logic [2*LANE_W-1:0]   rsp_rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_ce_n,
    output logic                  mem_ce,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic                  mem_lb_n,
    output logic                  mem_ub_n,
    output logic [2*LANE_W-1:0]   mem_dq_o,
    output logic                  mem_dq_oe,
    input  logic [2*LANE_W-1:0]   mem_dq_i
);
    localparam int unsigned LANES    = 2;
    localparam int unsigned RD_CYC   = umax(umax(umax(ps_to_cyc(T_RC_PS, CLK_PS),
                                                      ps_to_cyc(T_AA_PS, CLK_PS)),
                                                 ps_to_cyc(T_DOE_PS, CLK_PS)), 1);
    localparam int unsigned WC_CYC   = ps_to_cyc(T_WC_PS, CLK_PS);
    localparam int unsigned WC_REST  = (WC_CYC > 2) ? (WC_CYC - 2) : 1;
    localparam int unsigned WE_CYC   = umax(umax(ps_to_cyc(T_PWE_PS, CLK_PS),
                                                 ps_to_cyc(T_SD_PS, CLK_PS)), WC_REST);
    localparam int unsigned TURN_CYC = umax(ps_to_cyc(T_HZOE_PS, CLK_PS), 1);
    localparam int unsigned PWR_CYC  = umax(ps_to_cyc(T_PWR_PS, CLK_PS), 1);
    localparam int unsigned CNT_MAX  = umax(umax(RD_CYC, WE_CYC), umax(TURN_CYC, PWR_CYC));
    localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1);

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             accept;
    logic             capture;
    logic [LANES-1:0] lane_mask;
    logic [LANES-1:0] lane_n;

    sram_lane_timer #(
        .W       (CNT_W),
        .RST_VAL (PWR_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sram_lane_fsm #(
        .LANES    (LANES),
        .CNT_W    (CNT_W),
        .RD_CYC   (RD_CYC),
        .WE_CYC   (WE_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .lane_mask (lane_mask),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .ce_n      (mem_ce_n),
        .ce        (mem_ce),
        .oe_n      (mem_oe_n),
        .we_n      (mem_we_n),
        .lane_n    (lane_n),
        .dq_oe     (mem_dq_oe)
    );

    sram_lane_dpath #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_mask  (req_lane_en),
        .mem_dq_i  (mem_dq_i),
        .mem_addr  (mem_addr),
        .mem_dq_o  (mem_dq_o),
        .lane_mask (lane_mask),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    assign mem_lb_n = lane_n[0];
    assign mem_ub_n = lane_n[1];
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram_lane_ctrl_chk #(
    parameter int unsigned PWR_CYC = 1,
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned DATA_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic              mem_lb_n,
    input logic              mem_ub_n,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);
    int unsigned edges;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edges <= 0;
        end else if (edges < PWR_CYC) begin
            edges <= edges + 1;
        end
    end

    // R1: host held off and memory deselected during the supply wait
    p_pwrup_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (edges < PWR_CYC) |-> (!req_ready && mem_ce_n && !mem_ce));

    // R8: idle means deselected, quiet strobes, bus released
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_ce && mem_oe_n && mem_we_n &&
                       mem_lb_n && mem_ub_n && !mem_dq_oe));

    // R3: output enable only with both selects active and write enable high
    p_read_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_ce_n && mem_ce && mem_we_n));

    // R4: result strobe is one cycle wide and follows a read window
    p_rsp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_rsp_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(!mem_oe_n));

    // R5: write pulse happens with selects active, bus driven and output enable high
    p_write_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_ce_n && mem_ce));
    p_write_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> ($past(mem_dq_oe) && $stable(mem_addr) && $stable(mem_dq_o)));

    // R7: no overlap of drivers, and a released cycle before driving
    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);
    p_release_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> $past(mem_oe_n));

    // R9: address and data held across the end of the write
    p_write_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_o)));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .PWR_CYC (PWR_CYC),
    .ADDR_W  (ADDR_W),
    .DATA_W  (2*LANE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .mem_addr  (mem_addr),
    .mem_ce_n  (mem_ce_n),
    .mem_ce    (mem_ce),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_lb_n  (mem_lb_n),
    .mem_ub_n  (mem_ub_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_bench.sv
`timescale 1ns/1ps
module sram_lane_ctrl_bench;
    // Timing figures given to the design; the bench derives its own counts.
    localparam int CLK_PS = 8000;
    localparam int T_RC = 10000, T_AA = 10000, T_DOE = 5000, T_PWE = 7000;
    localparam int T_SD = 5500, T_WC = 10000, T_HZOE = 5000, T_PWR = 100000000;

    function automatic int up(input int ps);
        return (ps + CLK_PS - 1) / CLK_PS;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int RD_CYC   = mx(mx(mx(up(T_RC), up(T_AA)), up(T_DOE)), 1);
    localparam int WC_REST  = (up(T_WC) > 2) ? up(T_WC) - 2 : 1;
    localparam int WE_CYC   = mx(mx(up(T_PWE), up(T_SD)), WC_REST);
    localparam int TURN_CYC = mx(up(T_HZOE), 1);
    localparam int PWR_CYC  = mx(up(T_PWR), 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_lane_en = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_dq_o;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_i;

    always #4 clk = ~clk;

    sram_lane_ctrl #(
        .CLK_PS (CLK_PS), .T_RC_PS (T_RC), .T_AA_PS (T_AA), .T_DOE_PS (T_DOE),
        .T_PWE_PS (T_PWE), .T_SD_PS (T_SD), .T_WC_PS (T_WC), .T_HZOE_PS (T_HZOE),
        .T_PWR_PS (T_PWR)
    ) u_sram_lane_ctrl (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_lane_en (req_lane_en),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .mem_addr (mem_addr), .mem_ce_n (mem_ce_n), .mem_ce (mem_ce),
        .mem_oe_n (mem_oe_n), .mem_we_n (mem_we_n), .mem_lb_n (mem_lb_n),
        .mem_ub_n (mem_ub_n), .mem_dq_o (mem_dq_o), .mem_dq_oe (mem_dq_oe),
        .mem_dq_i (mem_dq_i)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    // Device model: 256 words addressed by the low address byte.
    logic [15:0] dev_mem [256];
    logic [15:0] exp_mem [256];
    logic [15:0] dev_word;
    logic        dev_rd;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) dev_mem[i] = 16'h0000;
        end else if (!mem_ce_n && mem_ce && !mem_we_n) begin
            if (!mem_lb_n) dev_mem[mem_addr[7:0]][7:0]  = mem_dq_o[7:0];
            if (!mem_ub_n) dev_mem[mem_addr[7:0]][15:8] = mem_dq_o[15:8];
        end
    end

    always @* begin
        dev_rd   = !mem_ce_n && mem_ce && !mem_oe_n && mem_we_n;
        dev_word = dev_mem[mem_addr[7:0]];
        mem_dq_i[15:8] = (dev_rd && !mem_ub_n) ? dev_word[15:8] : 8'hA5;
        mem_dq_i[7:0]  = (dev_rd && !mem_lb_n) ? dev_word[7:0]  : 8'h5A;
    end

    // Scoreboard
    logic [15:0] exp_q [$];
    int          due_q [$];
    logic [19:0] cur_addr = '0;
    logic [15:0] cur_wdata = '0;
    logic [1:0]  cur_be = '0;

    int  rd_len = 0, wr_len = 0, gap = 0;
    bit  rd_bad = 0, wr_bad = 0, gap_on = 0, prev_dq_oe = 0;
    bit  contention = 0, idle_bad = 0, pw_bad = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R4", "unexpected response", rsp_rdata, 0);
                end else begin
                    logic [15:0] e;
                    int d;
                    e = exp_q.pop_front();
                    d = due_q.pop_front();
                    chk(rsp_rdata == e, "R4", "read data", rsp_rdata, e);
                    chk(cyc == d, "R4", "response edge", cyc, d);
                end
            end
            // Read windows (R3)
            if (!mem_oe_n) begin
                rd_len++;
                if (mem_addr != cur_addr || {mem_ub_n, mem_lb_n} != ~cur_be) rd_bad = 1;
            end else if (rd_len != 0) begin
                chk(rd_len == RD_CYC, "R3", "output enable window length", rd_len, RD_CYC);
                chk(!rd_bad, "R3", "read address and lane pins", rd_bad, 0);
                rd_len = 0; rd_bad = 0; gap = 1; gap_on = 1;
            end else if (gap_on && !mem_dq_oe) begin
                gap++;
            end
            // Turnaround before driving (R7) and setup cycle (R5)
            if (mem_dq_oe && !prev_dq_oe) begin
                chk(mem_we_n && mem_dq_o == cur_wdata, "R5", "setup cycle before pulse",
                    {mem_we_n, mem_dq_o}, {1'b1, cur_wdata});
                if (gap_on) begin
                    chk(gap >= TURN_CYC, "R7", "released cycles before drive", gap, TURN_CYC);
                    gap_on = 0;
                end
            end
            prev_dq_oe = mem_dq_oe;
            // Write windows (R5, R6, R9)
            if (!mem_we_n) begin
                wr_len++;
                if (mem_addr != cur_addr || mem_dq_o != cur_wdata ||
                    {mem_ub_n, mem_lb_n} != ~cur_be || !mem_oe_n || !mem_dq_oe) wr_bad = 1;
            end else if (wr_len != 0) begin
                chk(wr_len == WE_CYC, "R5", "write pulse length", wr_len, WE_CYC);
                chk(!wr_bad, "R9", "pins steady during pulse (lanes per R6)", wr_bad, 0);
                chk(mem_dq_oe && mem_dq_o == cur_wdata && mem_addr == cur_addr, "R9",
                    "hold in recovery cycle", mem_dq_o, cur_wdata);
                wr_len = 0; wr_bad = 0;
            end
            if (mem_dq_oe && !mem_oe_n) contention = 1;
            if (req_ready && !(mem_ce_n && !mem_ce && mem_oe_n && mem_we_n &&
                               mem_lb_n && mem_ub_n && !mem_dq_oe)) idle_bad = 1;
            if (cyc < PWR_CYC && (req_ready || !mem_ce_n)) pw_bad = 1;
        end
    end

    task automatic access(input bit wr, input logic [19:0] a, input logic [15:0] d,
                          input logic [1:0] be);
        int acc;
        int want;
        logic [15:0] m;
        cur_addr = a; cur_wdata = d; cur_be = be;
        req_write = wr; req_addr = a; req_wdata = d; req_lane_en = be; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        acc = cyc + 1;
        m = exp_mem[a[7:0]];
        if (wr) begin
            if (be[0]) m[7:0]  = d[7:0];
            if (be[1]) m[15:8] = d[15:8];
            exp_mem[a[7:0]] = m;
        end else begin
            exp_q.push_back({be[1] ? m[15:8] : 8'h00, be[0] ? m[7:0] : 8'h00});
            due_q.push_back(acc + RD_CYC);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2", "ready low after accept", req_ready, 0);
        while (!req_ready) @(negedge clk);
        want = wr ? acc + WE_CYC + 2 : acc + RD_CYC + TURN_CYC;
        chk(cyc == want, wr ? "R2" : "R7", "ready return edge", cyc, want);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) exp_mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        chk(!req_ready && mem_ce_n && !mem_ce && mem_oe_n && mem_we_n && !mem_dq_oe,
            "R8", "pins in reset", {req_ready, mem_ce_n, mem_ce, mem_oe_n, mem_we_n, mem_dq_oe},
            6'b010110);
        rst_n = 1'b1;
        // R1: request waiting during the supply wait
        req_write = 1'b1; req_addr = 20'h00010; req_wdata = 16'h1234;
        req_lane_en = 2'b11; req_valid = 1'b1;
        cur_addr = 20'h00010; cur_wdata = 16'h1234; cur_be = 2'b11;
        while (cyc != PWR_CYC - 1) @(negedge clk);
        chk(!req_ready && mem_ce_n, "R1", "held off one edge before end of wait",
            {req_ready, mem_ce_n}, 2'b01);
        @(negedge clk);
        chk(req_ready, "R1", "ready after supply wait", req_ready, 1);
        access(1'b1, 20'h00010, 16'h1234, 2'b11);
        access(1'b0, 20'h00010, 16'h0000, 2'b11);          // R4 full read
        access(1'b1, 20'h00010, 16'hABCD, 2'b01);          // R6 lower lane only
        access(1'b0, 20'h00010, 16'h0000, 2'b11);
        access(1'b1, 20'h00010, 16'h5678, 2'b10);          // R6 upper lane only
        access(1'b0, 20'h00010, 16'h0000, 2'b01);          // R4 lower read, upper zero
        access(1'b0, 20'h00010, 16'h0000, 2'b10);          // R4 upper read, lower zero
        access(1'b1, 20'h00010, 16'hFFFF, 2'b00);          // R10 zero-mask write
        access(1'b0, 20'h00010, 16'h0000, 2'b11);
        access(1'b0, 20'h00010, 16'h0000, 2'b00);          // R10 zero-mask read
        access(1'b1, 20'hFFFFF, 16'hA55A, 2'b11);
        access(1'b1, 20'h80020, 16'h0F0F, 2'b11);
        access(1'b0, 20'hFFFFF, 16'h0000, 2'b11);
        access(1'b0, 20'h80020, 16'h0000, 2'b11);
        for (int i = 0; i < 6; i++) begin
            access(1'b1, 20'(32'h40 + i * 32'h1011), 16'(32'h3C00 + i * 32'h0111), 2'(i % 4));
            access(1'b0, 20'(32'h40 + i * 32'h1011), 16'h0000, 2'b11);
        end
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R4", "all responses seen", exp_q.size(), 0);
        chk(!contention, "R7", "no bus overlap", contention, 0);
        chk(!idle_bad, "R8", "quiet pins while ready", idle_bad, 0);
        chk(!pw_bad, "R1", "deselected during supply wait", pw_bad, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule